// File: doc/BRIEF.md
# BCD Calendar Clock Register File

This block keeps wall-clock time and date as packed BCD. It holds seconds, minutes, 24-hour hours, day of week, day of month, month, two-digit year and a century flag. The host sees them as eight byte-wide registers in the top eight locations of a byte-addressed space and reads or writes them like ordinary memory. Any address whose upper bits are not all ones belongs to other storage and is not decoded here.

The clock itself lives in private counters that advance on a single-cycle one-second strobe. The host only ever touches a set of copy registers. The copies follow the counters on every second unless the host freezes them. A freeze for reading holds a consistent snapshot while the counters keep running. A freeze for setting lets the host compose a new time in the copies, and the counters load that time when the freeze is released. A stop flag halts the counters entirely. A century flag can be made to flip each time the year wraps from 99 to 00.

Top module: `bcd_rtc_regs`

## Requirements
- R1: The block answers only when the select is high and every address bit above the low three is 1. The low three bits pick the register: 0 control, 1 seconds, 2 minutes, 3 hours, 4 century/day, 5 date, 6 month, 7 year. Any other address reads as 0x00, and a write to it changes no register.
- R2: On a strobe while running, seconds count 00..59. Each wrap of a field carries into the next: seconds into minutes (00..59), minutes into hours (00..23), hours into day of week (1..7, 7 wraps to 1) and date. All fields advance in that one clock cycle.
- R3: Bit 7 of the seconds register is a stop flag. While it is 1, strobes leave all time fields unchanged. After it is written to 0, the next strobe advances time again.
- R4: In the century/day register, bit 5 enables the century flag and bit 4 is that flag. When bit 5 is 1, bit 4 inverts as the year wraps from 99 to 00. When bit 5 is 0, bit 4 keeps its value. Both bits take a write at any time, without the set freeze, and read back at once.
- R5: Control bit 6 freezes the copies while the counters keep running. A strobe in the same cycle as the write that sets the bit still lands in the copies. After the bit is cleared, the next strobe shows the current counter time.
- R6: Control bit 7 also freezes the copies. Host writes go to the copies. Writing 0 to bit 7 while it is 1 loads all seven time registers into the counters, and the next strobe advances from the loaded time.
- R7: The date wraps to 01 and the month advances after day 31, after day 30 in months 04, 06, 09 and 11, and in month 02 after day 29 or day 28. Day 29 applies when the year's value is a multiple of 4. Month 12 wraps to 01 and advances the year.
- R8: After reset the control byte is 0x00, so both freeze bits are clear. The frequency-test bit (century/day bit 6), the stop flag and both century bits are 0. The time reads 00:00:00, day 1, date 01, month 01, year 00.
- R9: Bits with no meaning read as 0. This covers seconds or minutes bit 7 (except the stop flag), hours bits 7:6, century/day bits 7 and 3, date bits 7:6 and month bits 7:5. The control byte reads back as written.
- R10: Without a freeze, a strobe updates the copies in the same clock edge as the counters, so a read in the following cycle shows the new time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle strobe that advances the clock by one second |
| bus_cs | input | 1 | Host access select |
| bus_we | input | 1 | Host write enable, qualified by bus_cs |
| bus_addr | input | ADDR_W | Host byte address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data for the addressed register, 0 when not addressed |

## Verification
On every cycle, the assertions check these invariants:
- the copies hold still under either freeze unless the host writes them
- the counters hold still while stopped
- the century flag holds while disabled
- a load makes the counters equal the previous copies
- every running strobe moves the seconds

Some behaviour only the bench scenarios can show. This covers the carry chains across minute, hour, day and month wraps. It covers the month-length and leap-year corner dates, and the century flip at year 99. It also covers the order of a strobe against a freeze write in the same cycle, and the masking of meaningless bits.

// File: rtl/bcd_rtc_regs.sv
module bcd_rtc_regs #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata
);

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  logic [2:0] sel;
  logic       hit, wr_hit;
  assign sel    = bus_addr[2:0];
  assign hit    = bus_cs && (&bus_addr[ADDR_W-1:3]);
  assign wr_hit = hit && bus_we;

  logic [7:0] ctrl_q;
  logic       stop_q, ft_q, ceb_q, cb_q;

  logic [6:0] c_sec, c_min, r_sec, r_min;
  logic [5:0] c_hr, c_date, r_hr, r_date;
  logic [2:0] c_day, r_day;
  logic [4:0] c_mon, r_mon;
  logic [7:0] c_yr, r_yr;

  logic [7:0] inc_sec, inc_min, inc_hr, inc_date, inc_mon, inc_yr;
  assign inc_sec  = bcd_inc({1'b0, c_sec});
  assign inc_min  = bcd_inc({1'b0, c_min});
  assign inc_hr   = bcd_inc({2'b0, c_hr});
  assign inc_date = bcd_inc({2'b0, c_date});
  assign inc_mon  = bcd_inc({3'b0, c_mon});
  assign inc_yr   = bcd_inc(c_yr);

  logic unused_inc;
  assign unused_inc = ^{inc_sec[7], inc_min[7], inc_hr[7:6], inc_date[7:6], inc_mon[7:5]};

  logic       leap;
  logic [5:0] last_date;
  assign leap = c_yr[4] ? (c_yr[3:0] == 4'd2 || c_yr[3:0] == 4'd6)
                        : (c_yr[3:0] == 4'd0 || c_yr[3:0] == 4'd4 || c_yr[3:0] == 4'd8);

  always_comb begin
    case (c_mon)
      5'h02:                      last_date = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_date = 6'h30;
      default:                    last_date = 6'h31;
    endcase
  end

  logic sec_wrap, min_wrap, hr_wrap, date_wrap, mon_wrap, yr_wrap;
  assign sec_wrap  = c_sec  >= 7'h59;
  assign min_wrap  = c_min  >= 7'h59;
  assign hr_wrap   = c_hr   >= 6'h23;
  assign date_wrap = c_date >= last_date;
  assign mon_wrap  = c_mon  >= 5'h12;
  assign yr_wrap   = c_yr   >= 8'h99;

  logic adv, en_min, en_hr, en_day, en_mon, en_yr, cent;
  assign adv    = tick_1hz && !stop_q;
  assign en_min = adv    && sec_wrap;
  assign en_hr  = en_min && min_wrap;
  assign en_day = en_hr  && hr_wrap;
  assign en_mon = en_day && date_wrap;
  assign en_yr  = en_mon && mon_wrap;
  assign cent   = en_yr  && yr_wrap;

  logic [6:0] nx_sec, nx_min;
  logic [5:0] nx_hr, nx_date;
  logic [2:0] nx_day;
  logic [4:0] nx_mon;
  logic [7:0] nx_yr;

  assign nx_sec  = !adv    ? c_sec  : sec_wrap  ? 7'h00 : inc_sec[6:0];
  assign nx_min  = !en_min ? c_min  : min_wrap  ? 7'h00 : inc_min[6:0];
  assign nx_hr   = !en_hr  ? c_hr   : hr_wrap   ? 6'h00 : inc_hr[5:0];
  assign nx_day  = !en_day ? c_day  : (c_day == 3'd7 || c_day == 3'd0) ? 3'd1 : c_day + 3'd1;
  assign nx_date = !en_day ? c_date : date_wrap ? 6'h01 : inc_date[5:0];
  assign nx_mon  = !en_mon ? c_mon  : mon_wrap  ? 5'h01 : inc_mon[4:0];
  assign nx_yr   = !en_yr  ? c_yr   : yr_wrap   ? 8'h00 : inc_yr;

  logic frz, upd, ld;
  assign frz = ctrl_q[6] || ctrl_q[7];
  assign upd = adv && !frz;
  assign ld  = wr_hit && sel == 3'd0 && ctrl_q[7] && !bus_wdata[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {c_sec, c_min, c_hr} <= '0;
      c_day  <= 3'd1;
      c_date <= 6'h01;
      c_mon  <= 5'h01;
      c_yr   <= 8'h00;
    end else if (ld) begin
      {c_sec, c_min, c_hr, c_day, c_date, c_mon, c_yr} <=
        {r_sec, r_min, r_hr, r_day, r_date, r_mon, r_yr};
    end else begin
      {c_sec, c_min, c_hr, c_day, c_date, c_mon, c_yr} <=
        {nx_sec, nx_min, nx_hr, nx_day, nx_date, nx_mon, nx_yr};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 8'h00;
      stop_q <= 1'b0;
      ft_q   <= 1'b0;
      ceb_q  <= 1'b0;
      cb_q   <= 1'b0;
    end else begin
      if (cent && ceb_q && !ld) cb_q <= ~cb_q;
      if (wr_hit) begin
        case (sel)
          3'd0: ctrl_q <= bus_wdata;
          3'd1: stop_q <= bus_wdata[7];
          3'd4: {ft_q, ceb_q, cb_q} <= bus_wdata[6:4];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {r_sec, r_min, r_hr} <= '0;
      r_day  <= 3'd1;
      r_date <= 6'h01;
      r_mon  <= 5'h01;
      r_yr   <= 8'h00;
    end else begin
      if (upd)
        {r_sec, r_min, r_hr, r_day, r_date, r_mon, r_yr} <=
          {nx_sec, nx_min, nx_hr, nx_day, nx_date, nx_mon, nx_yr};
      if (wr_hit) begin
        case (sel)
          3'd1: r_sec  <= bus_wdata[6:0];
          3'd2: r_min  <= bus_wdata[6:0];
          3'd3: r_hr   <= bus_wdata[5:0];
          3'd4: r_day  <= bus_wdata[2:0];
          3'd5: r_date <= bus_wdata[5:0];
          3'd6: r_mon  <= bus_wdata[4:0];
          3'd7: r_yr   <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (hit) begin
      case (sel)
        3'd0: bus_rdata = ctrl_q;
        3'd1: bus_rdata = {stop_q, r_sec};
        3'd2: bus_rdata = {1'b0, r_min};
        3'd3: bus_rdata = {2'b0, r_hr};
        3'd4: bus_rdata = {1'b0, ft_q, ceb_q, cb_q, 1'b0, r_day};
        3'd5: bus_rdata = {2'b0, r_date};
        3'd6: bus_rdata = {3'b0, r_mon};
        default: bus_rdata = r_yr;
      endcase
    end
  end

  logic [41:0] cnt_vec, cpy_vec;
  assign cnt_vec = {c_sec, c_min, c_hr, c_day, c_date, c_mon, c_yr};
  assign cpy_vec = {r_sec, r_min, r_hr, r_day, r_date, r_mon, r_yr};

  AST_TICK_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ld) |=> (c_sec != $past(c_sec))); // R2
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !ld) |=> $stable(cnt_vec)); // R3
  AST_CENTURY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ceb_q && !(wr_hit && sel == 3'd4)) |=> $stable(cb_q)); // R4
  AST_FREEZE_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    (frz && !(wr_hit && sel != 3'd0)) |=> $stable(cpy_vec)); // R5
  AST_LOAD_COUNTERS: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt_vec == $past(cpy_vec))); // R6

endmodule

// File: tb/bcd_rtc_regs_tb.sv
module bcd_rtc_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, cs = 1'b0, we = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;

  always #5 clk = ~clk;

  bcd_rtc_regs #(.ADDR_W(15)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick), .bus_cs(cs), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata)
  );

  int n_chk = 0, n_bad = 0;
  int m_sec = 0, m_min = 0, m_hr = 0, m_day = 1, m_date = 1, m_mon = 1, m_yr = 0;
  logic [7:0] p_sec = 0, p_min = 0, p_hr = 0, p_day = 1, p_date = 8'h01, p_mon = 8'h01, p_yr = 0;
  logic [7:0] m_ctrl = 0;
  bit m_stop = 0, m_ft = 0, m_ceb = 0, m_cb = 0;

  function automatic logic [7:0] bcd(input int b); return 8'((b / 10) * 16 + b % 10); endfunction
  function automatic int bin(input logic [7:0] x); return int'(x[7:4]) * 10 + int'(x[3:0]); endfunction
  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic void advance();
    if (m_sec < 59) begin m_sec++; return; end
    m_sec = 0;
    if (m_min < 59) begin m_min++; return; end
    m_min = 0;
    if (m_hr < 23) begin m_hr++; return; end
    m_hr = 0;
    m_day = (m_day >= 7) ? 1 : m_day + 1;
    if (m_date < mdays(m_mon, m_yr)) begin m_date++; return; end
    m_date = 1;
    if (m_mon < 12) begin m_mon++; return; end
    m_mon = 1;
    if (m_yr < 99) begin m_yr++; return; end
    m_yr = 0;
    if (m_ceb) m_cb = !m_cb;
  endfunction

  function automatic void model_step(input bit t, input bit w, input logic [2:0] s, input logic [7:0] d);
    bit frz = m_ctrl[6] || m_ctrl[7];
    bit ld  = w && s == 0 && m_ctrl[7] && !d[7];
    bit adv = t && !m_stop;
    if (ld) begin
      m_sec = bin(p_sec); m_min = bin(p_min); m_hr = bin(p_hr); m_day = int'(p_day);
      m_date = bin(p_date); m_mon = bin(p_mon); m_yr = bin(p_yr);
    end else if (adv) advance();
    if (adv && !frz) begin
      p_sec = bcd(m_sec); p_min = bcd(m_min); p_hr = bcd(m_hr); p_day = 8'(m_day);
      p_date = bcd(m_date); p_mon = bcd(m_mon); p_yr = bcd(m_yr);
    end
    if (w) case (s)
      3'd0: m_ctrl = d;
      3'd1: begin p_sec = d & 8'h7F; m_stop = d[7]; end
      3'd2: p_min = d & 8'h7F;
      3'd3: p_hr = d & 8'h3F;
      3'd4: begin p_day = d & 8'h07; m_ft = d[6]; m_ceb = d[5]; m_cb = d[4]; end
      3'd5: p_date = d & 8'h3F;
      3'd6: p_mon = d & 8'h1F;
      default: p_yr = d;
    endcase
  endfunction

  function automatic logic [7:0] exp_reg(input logic [2:0] s);
    case (s)
      3'd0: return m_ctrl;
      3'd1: return {m_stop, p_sec[6:0]};
      3'd2: return p_min;
      3'd3: return p_hr;
      3'd4: return {1'b0, m_ft, m_ceb, m_cb, 1'b0, p_day[2:0]};
      3'd5: return p_date;
      3'd6: return p_mon;
      default: return p_yr;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic cyc(input bit t, input bit w, input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    tick = t; cs = w; we = w; addr = {12'hFFF, s}; wdata = d;
    @(posedge clk);
    model_step(t, w, s, d);
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] v);
    @(negedge clk);
    tick = 0; cs = 1; we = 0; addr = {12'hFFF, s};
    #1 v = rdata;
  endtask

  task automatic cmp_all(input string tag);
    logic [7:0] v;
    for (int s = 0; s < 8; s++) begin
      rd(3'(s), v);
      chk(tag, v, exp_reg(3'(s)));
    end
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] s, input logic [7:0] exp);
    logic [7:0] v;
    rd(s, v);
    chk(tag, v, exp);
  endtask

  task automatic set_time(input logic [7:0] yr, mon, date, dayreg, hr, mn, sc);
    cyc(0, 1, 0, 8'h80);
    cyc(0, 1, 1, sc);  cyc(0, 1, 2, mn); cyc(0, 1, 3, hr); cyc(0, 1, 4, dayreg);
    cyc(0, 1, 5, date); cyc(0, 1, 6, mon); cyc(0, 1, 7, yr);
    cyc(0, 1, 0, 8'h00);
  endtask

  function automatic logic [7:0] rand_val(input logic [2:0] s);
    case (s)
      3'd0: return 8'($urandom);
      3'd1: return {($urandom % 8) == 0, 7'(bcd($urandom % 60))};
      3'd2: return bcd($urandom % 60);
      3'd3: return bcd($urandom % 24);
      3'd4: return {1'b0, 3'($urandom), 1'b0, 3'(1 + $urandom % 7)};
      3'd5: return bcd(1 + $urandom % 28);
      3'd6: return bcd(1 + $urandom % 12);
      default: return bcd($urandom % 100);
    endcase
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    cmp_all("R8 reset state");

    // R10 and R2: plain seconds advance, visible next cycle
    cyc(1, 0, 0, 0);
    rd_chk("R10 copy follows tick", 3'd1, 8'h01);

    // R2: carry through hours into day/date
    set_time(8'h05, 8'h06, 8'h14, 8'h07, 8'h23, 8'h59, 8'h59);
    cyc(1, 0, 0, 0);
    rd_chk("R2 seconds wrap", 3'd1, 8'h00);
    rd_chk("R2 minutes wrap", 3'd2, 8'h00);
    rd_chk("R2 hours wrap", 3'd3, 8'h00);
    rd_chk("R2 day 7 to 1", 3'd4, 8'h01);
    rd_chk("R2 date carry", 3'd5, 8'h15);

    // R7: leap February, common February, 30-day month
    set_time(8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
    cyc(1, 0, 0, 0);
    rd_chk("R7 leap Feb 29", 3'd5, 8'h29);
    rd_chk("R7 leap month kept", 3'd6, 8'h02);
    set_time(8'h23, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
    cyc(1, 0, 0, 0);
    rd_chk("R7 common Feb wrap date", 3'd5, 8'h01);
    rd_chk("R7 common Feb to Mar", 3'd6, 8'h03);
    set_time(8'h41, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
    cyc(1, 0, 0, 0);
    rd_chk("R7 Apr 30 wrap", 3'd5, 8'h01);
    rd_chk("R7 Apr to May", 3'd6, 8'h05);

    // R4: century flip when enabled, hold when disabled
    set_time(8'h99, 8'h12, 8'h31, 8'h27, 8'h23, 8'h59, 8'h59);
    cyc(1, 0, 0, 0);
    rd_chk("R4 century toggles", 3'd4, 8'h31);
    rd_chk("R7 year wrap", 3'd7, 8'h00);
    rd_chk("R7 month wrap", 3'd6, 8'h01);
    set_time(8'h99, 8'h12, 8'h31, 8'h17, 8'h23, 8'h59, 8'h59);
    cyc(1, 0, 0, 0);
    rd_chk("R4 century held", 3'd4, 8'h11);
    cyc(0, 1, 4, 8'h35);
    rd_chk("R4 write without freeze", 3'd4, 8'h35);
    cmp_all("R4 model");

    // R5: read freeze, tick landing in same cycle as freeze write
    set_time(8'h10, 8'h03, 8'h03, 8'h02, 8'h08, 8'h00, 8'h10);
    @(negedge clk);
    tick = 1; cs = 1; we = 1; addr = 15'h7FF8; wdata = 8'h40;
    @(posedge clk); model_step(1, 1, 0, 8'h40);
    rd_chk("R5 tick during freeze write lands", 3'd1, 8'h11);
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
    rd_chk("R5 copies frozen", 3'd1, 8'h11);
    cyc(0, 1, 0, 8'h00);
    cyc(1, 0, 0, 0);
    rd_chk("R5 counters kept running", 3'd1, 8'h15);

    // R6: set freeze, tick while set, load on release
    cyc(0, 1, 0, 8'h80);
    cyc(0, 1, 1, 8'h45);
    cyc(1, 0, 0, 0);
    rd_chk("R6 copies hold host value", 3'd1, 8'h45);
    cyc(0, 1, 0, 8'h00);
    cyc(1, 0, 0, 0);
    rd_chk("R6 advance from loaded", 3'd1, 8'h46);

    // R3: stop flag
    cyc(0, 1, 1, 8'hA0);
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
    rd_chk("R3 stopped", 3'd1, 8'hA0);
    cyc(0, 1, 1, 8'h20);
    cyc(1, 0, 0, 0);
    rd_chk("R3 resume from counter", 3'd1, 8'h47);

    // R9: meaningless bits read as zero
    cyc(0, 1, 0, 8'h80);
    cyc(0, 1, 2, 8'hFF); cyc(0, 1, 3, 8'hFF); cyc(0, 1, 4, 8'hBF);
    cyc(0, 1, 5, 8'hFF); cyc(0, 1, 6, 8'hFF);
    rd_chk("R9 minutes mask", 3'd2, 8'h7F);
    rd_chk("R9 hours mask", 3'd3, 8'h3F);
    rd_chk("R9 day mask", 3'd4, 8'h37);
    rd_chk("R9 date mask", 3'd5, 8'h3F);
    rd_chk("R9 month mask", 3'd6, 8'h1F);
    rd_chk("R9 control as written", 3'd0, 8'h80);
    set_time(8'h30, 8'h07, 8'h04, 8'h04, 8'h12, 8'h00, 8'h00);

    // R1: out-of-range addresses
    @(negedge clk);
    tick = 0; cs = 1; we = 1; addr = 15'h7FF1; wdata = 8'h33;
    @(posedge clk);
    @(negedge clk);
    tick = 0; cs = 1; we = 1; addr = 15'h0009; wdata = 8'h33;
    @(posedge clk);
    @(negedge clk);
    we = 0; addr = 15'h3FFA;
    #1 chk("R1 undecoded read zero", rdata, 8'h00);
    cmp_all("R1 undecoded writes ignored");

    // Random mix against model
    for (int i = 0; i < 2000; i++) begin
      automatic int r = $urandom % 8;
      if (r < 3) cyc(1, 0, 0, 0);
      else if (r < 5) begin
        automatic logic [2:0] s = 3'($urandom);
        cyc(0, 1, s, rand_val(s));
      end else cyc(0, 0, 0, 0);
      if (i % 40 == 39) cmp_all("R2 random mix");
    end
    cmp_all("R10 final");
    finish_run();
  end
endmodule